// File: doc/BRIEF.md
# Processor Interrupt Interface

This block sits between an interrupt distributor and a single processor. Each cycle the distributor offers its best candidate: an ID, a priority and, for software-generated interrupts, the number of the processor that sent it. The block decides whether that candidate deserves the processor's attention. It compares the candidate against a programmable priority mask and against the priority of the interrupt already being serviced. Only a candidate that beats both raises the request line. A lower numeric value means a more urgent priority.

The processor talks to the block through a small register port. The port has a read side and a write side, and both may be used in the same cycle. Reading the acknowledge address claims the current candidate and returns its ID. The block pushes that candidate's priority onto a running-priority stack, so a more urgent interrupt can nest on top of it. Writing an ID to the end-of-interrupt address pops the stack. Both events are sent back to the distributor's state tracking as one-cycle strobes that carry the interrupt ID.

Top module: `irq_cpu_port`

## Requirements
- R1: `irq_o` is high in a cycle exactly when `cand_valid_i` is high, `cand_prio_i` is numerically lower than the mask, `cand_prio_i` is numerically lower than the running priority, and the stack is not full. The mask is written at write address 0 (`wr_data_i[7:0]`) and read back at read address 0. A mask write takes effect on the next cycle.
- R2: A read at address 1 (acknowledge) in a cycle where `irq_o` is high returns the candidate ID in `rd_data_o[9:0]` on the following cycle. In that same following cycle, `ack_o` pulses for one cycle with `ack_id_o` equal to the ID.
- R3: In acknowledge data, bits [12:10] hold `cand_src_i` when the ID is below 16, and hold zero for any other ID. Bits [31:13] are always zero.
- R4: A successful acknowledge pushes the candidate priority onto the running-priority stack. A read at address 3 returns the top of the stack, or 0xFF when the stack is empty. A candidate whose priority equals the running priority does not raise `irq_o`.
- R5: An acknowledge read while `irq_o` is low returns 1023, gives no `ack_o` pulse and leaves the running priority unchanged.
- R6: A write at address 2 (end-of-interrupt, ID in `wr_data_i[9:0]`) pops the stack and pulses `eoi_o` with `eoi_id_o` set to the written ID. If the stack is empty, or the written ID is 1023, the write pops nothing and gives no pulse.
- R7: The stack holds 4 levels. While it is full, `irq_o` stays low and an acknowledge returns 1023.
- R8: When an acknowledge and an end-of-interrupt fall in the same cycle, the pop is applied before the push. The acknowledge is qualified against the state at the start of that cycle. The stack depth is therefore unchanged and the new priority replaces the top.
- R9: After reset the mask reads 0, the running priority reads 0xFF, and `irq_o`, `ack_o` and `eoi_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid_i | input | 1 | Distributor candidate present |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority (lower value is more urgent) |
| cand_src_i | input | 3 | Requesting processor for software interrupts |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Register read address (0 mask, 1 acknowledge, 3 running priority) |
| rd_data_o | output | 32 | Read data, valid the cycle after the read |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address (0 mask, 2 end-of-interrupt) |
| wr_data_i | input | 32 | Register write data |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Acknowledge pulse to state tracking |
| ack_id_o | output | 10 | ID of the acknowledged interrupt |
| eoi_o | output | 1 | End-of-interrupt pulse to state tracking |
| eoi_id_o | output | 10 | ID being retired |

## Verification
An acknowledge read and an end-of-interrupt write can land in the same cycle, because the read and write sides of the port are independent. The bench provokes this with one interrupt already active and a more urgent candidate waiting, then asserts both strobes on one clock edge. It then checks three things. Both pulses must appear with their own IDs. The running priority must read back as the new candidate's priority. A single further end-of-interrupt must return the priority to idle, which shows that the depth did not change.

// File: rtl/irqcp_pkg.sv
package irqcp_pkg;

    typedef enum logic [1:0] {
        RA_MASK = 2'd0,
        RA_ACK  = 2'd1,
        RA_EOI  = 2'd2,
        RA_RUN  = 2'd3
    } reg_addr_e;

    localparam int unsigned SPURIOUS_ID = 1023;

endpackage

// File: rtl/irqcp_prio_stack.sv
module irqcp_prio_stack #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] prio_i,
    output logic [PRIO_W-1:0] top_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t             stk_d, stk_q;
    logic [CNT_W-1:0] base_c;

    always_comb begin
        stk_d  = stk_q;
        base_c = stk_q.cnt;
        // pop first, then push onto the resulting level
        if (pop_i && (stk_q.cnt != '0)) begin
            base_c = stk_q.cnt - 1'b1;
        end
        stk_d.cnt = base_c;
        if (push_i && (base_c != CNT_W'(DEPTH))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (base_c == CNT_W'(i)) begin
                    stk_d.ent[i] = prio_i;
                end
            end
            stk_d.cnt = base_c + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    always_comb begin
        top_o = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (stk_q.cnt == CNT_W'(i + 1)) begin
                top_o = stk_q.ent[i];
            end
        end
    end

    assign empty_o = (stk_q.cnt == '0);
    assign full_o  = (stk_q.cnt == CNT_W'(DEPTH));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.cnt <= CNT_W'(DEPTH));

    p_push_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (stk_q.cnt == CNT_W'($past(stk_q.cnt) + 1'b1)));

    p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (stk_q.cnt == CNT_W'($past(stk_q.cnt) - 1'b1)));

    p_swap_keeps_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && push_i && !empty_o) |=> $stable(stk_q.cnt));

endmodule

// File: rtl/irqcp_gate.sv
module irqcp_gate #(
    parameter int unsigned PRIO_W = 8
) (
    input  logic              valid_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [PRIO_W-1:0] running_i,
    input  logic              full_i,
    output logic              take_o
);
    logic beats_mask_c;
    logic beats_run_c;

    always_comb begin
        beats_mask_c = (prio_i < mask_i);
        beats_run_c  = (prio_i < running_i);
        take_o       = valid_i && beats_mask_c && beats_run_c && !full_i;
    end

endmodule

// File: rtl/irqcp_ack_fmt.sv
module irqcp_ack_fmt #(
    parameter int unsigned ID_W      = 10,
    parameter int unsigned SRC_W     = 3,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SGI_COUNT = 16
) (
    input  logic [ID_W-1:0]   id_i,
    input  logic [SRC_W-1:0]  src_i,
    output logic [DATA_W-1:0] word_o
);
    logic is_sgi_c;

    always_comb begin
        is_sgi_c = (id_i < ID_W'(SGI_COUNT));
        word_o   = '0;
        word_o[ID_W-1:0] = id_i;
        if (is_sgi_c) begin
            word_o[ID_W +: SRC_W] = src_i;
        end
    end

endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
    parameter int unsigned ID_W      = 10,
    parameter int unsigned PRIO_W    = 8,
    parameter int unsigned SRC_W     = 3,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned SGI_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic [SRC_W-1:0]  cand_src_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              irq_o,
    output logic              ack_o,
    output logic [ID_W-1:0]   ack_id_o,
    output logic              eoi_o,
    output logic [ID_W-1:0]   eoi_id_o
);
    import irqcp_pkg::*;

    localparam logic [ID_W-1:0] SPUR = ID_W'(SPURIOUS_ID);

    typedef struct packed {
        logic [PRIO_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
        logic              ack;
        logic [ID_W-1:0]   ack_id;
        logic              eoi;
        logic [ID_W-1:0]   eoi_id;
    } port_t;

    port_t             st_d, st_q;
    logic              take_c;
    logic              rd_ack_c, wr_eoi_c, wr_mask_c;
    logic              push_c, pop_c;
    logic [PRIO_W-1:0] running_c;
    logic              stk_empty_c, stk_full_c;
    logic [DATA_W-1:0] ack_word_c;
    logic [ID_W-1:0]   wr_id_c;

    irqcp_gate #(.PRIO_W(PRIO_W)) u_gate (
        .valid_i   (cand_valid_i),
        .prio_i    (cand_prio_i),
        .mask_i    (st_q.mask),
        .running_i (running_c),
        .full_i    (stk_full_c),
        .take_o    (take_c)
    );

    irqcp_prio_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_c),
        .pop_i   (pop_c),
        .prio_i  (cand_prio_i),
        .top_o   (running_c),
        .empty_o (stk_empty_c),
        .full_o  (stk_full_c)
    );

    irqcp_ack_fmt #(
        .ID_W(ID_W), .SRC_W(SRC_W), .DATA_W(DATA_W), .SGI_COUNT(SGI_COUNT)
    ) u_fmt (
        .id_i   (cand_id_i),
        .src_i  (cand_src_i),
        .word_o (ack_word_c)
    );

    always_comb begin
        wr_id_c   = wr_data_i[ID_W-1:0];
        rd_ack_c  = rd_en_i && (rd_addr_i == RA_ACK);
        wr_eoi_c  = wr_en_i && (wr_addr_i == RA_EOI);
        wr_mask_c = wr_en_i && (wr_addr_i == RA_MASK);
        push_c    = rd_ack_c && take_c;
        pop_c     = wr_eoi_c && !stk_empty_c && (wr_id_c != SPUR);

        st_d     = st_q;
        st_d.ack = push_c;
        st_d.eoi = pop_c;
        if (push_c) begin
            st_d.ack_id = cand_id_i;
        end
        if (pop_c) begin
            st_d.eoi_id = wr_id_c;
        end
        if (wr_mask_c) begin
            st_d.mask = wr_data_i[PRIO_W-1:0];
        end
        if (rd_en_i) begin
            case (rd_addr_i)
                RA_MASK: st_d.rdata = DATA_W'(st_q.mask);
                RA_ACK:  st_d.rdata = take_c ? ack_word_c : DATA_W'(SPUR);
                RA_RUN:  st_d.rdata = DATA_W'(running_c);
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o     = take_c;
    assign rd_data_o = st_q.rdata;
    assign ack_o     = st_q.ack;
    assign ack_id_o  = st_q.ack_id;
    assign eoi_o     = st_q.eoi;
    assign eoi_id_o  = st_q.eoi_id;

    p_ack_follows_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(irq_o));

    p_spurious_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (rd_addr_i == RA_ACK) && !irq_o)
        |=> (!ack_o && (rd_data_o[ID_W-1:0] == SPUR)));

    p_eoi_needs_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_o |-> !$past(stk_empty_c));

    p_mask_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (wr_addr_i == RA_MASK)) |=> $stable(st_q.mask));

endmodule

// File: tb/sim_irq_cpu_port.sv
module sim_irq_cpu_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic [2:0]  cand_src = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq, ack, eoi;
    logic [9:0]  ack_id, eoi_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        ack_seen, eoi_seen;
    logic [9:0]  ack_id_seen, eoi_id_seen;
    logic [31:0] rdv;

    always #4 clk = ~clk;

    irq_cpu_port u0 (
        .clk(clk), .rst_n(rst_n),
        .cand_valid_i(cand_valid), .cand_id_i(cand_id),
        .cand_prio_i(cand_prio), .cand_src_i(cand_src),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id),
        .eoi_o(eoi), .eoi_id_o(eoi_id)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic set_cand(input bit v, input logic [9:0] id, input logic [7:0] p, input logic [2:0] s);
        @(negedge clk);
        cand_valid = v; cand_id = id; cand_prio = p; cand_src = s;
        #1;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); #1;
        d = rd_data; ack_seen = ack; ack_id_seen = ack_id;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        eoi_seen = eoi; eoi_id_seen = eoi_id;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_is(input string req, input logic [7:0] exp);
        logic [31:0] d;
        do_rd(2'd3, d);
        chk_eq(req, d, {24'd0, exp});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk_eq("R9 irq low", {31'd0, irq}, 32'd0);
        chk_eq("R9 ack low", {31'd0, ack}, 32'd0);
        chk_eq("R9 eoi low", {31'd0, eoi}, 32'd0);
        do_rd(2'd0, d);
        chk_eq("R9 mask reset", d, 32'd0);
        run_is("R9 running idle", 8'hFF);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        do_wr(2'd0, 32'h80);
        do_rd(2'd0, d);
        chk_eq("R1 mask readback", d, 32'h80);
        set_cand(1'b1, 10'd50, 8'h80, 3'd0);
        chk_eq("R1 equal to mask blocked", {31'd0, irq}, 32'd0);
        set_cand(1'b1, 10'd50, 8'h7F, 3'd0);
        chk_eq("R1 above mask raises", {31'd0, irq}, 32'd1);
        set_cand(1'b0, 10'd50, 8'h7F, 3'd0);
        chk_eq("R1 invalid blocked", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_nest;
        logic [31:0] d;
        set_cand(1'b1, 10'd5, 8'h40, 3'd3);
        do_rd(2'd1, d);
        chk_eq("R3 sgi ack data", d, 32'h0000_0C05);
        chk_eq("R2 ack strobe", {31'd0, ack_seen}, 32'd1);
        chk_eq("R2 ack id", {22'd0, ack_id_seen}, 32'd5);
        #1;
        chk_eq("R4 equal running blocked", {31'd0, irq}, 32'd0);
        run_is("R4 running after ack", 8'h40);
        set_cand(1'b1, 10'd40, 8'h20, 3'd3);
        chk_eq("R1 preempt raises", {31'd0, irq}, 32'd1);
        do_rd(2'd1, d);
        chk_eq("R3 non-sgi no source", d, 32'd40);
        run_is("R4 nested running", 8'h20);
        set_cand(1'b0, 10'd0, 8'h00, 3'd0);
        do_wr(2'd2, 32'd40);
        chk_eq("R6 eoi strobe", {31'd0, eoi_seen}, 32'd1);
        chk_eq("R6 eoi id", {22'd0, eoi_id_seen}, 32'd40);
        run_is("R6 pop restores outer", 8'h40);
        do_wr(2'd2, 32'd5);
        run_is("R6 pop to idle", 8'hFF);
    endtask

    task automatic t_spurious;
        logic [31:0] d;
        set_cand(1'b0, 10'd9, 8'h10, 3'd0);
        do_rd(2'd1, d);
        chk_eq("R5 spurious id", d, 32'd1023);
        chk_eq("R5 no ack strobe", {31'd0, ack_seen}, 32'd0);
        run_is("R5 running unchanged", 8'hFF);
    endtask

    task automatic t_full;
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            set_cand(1'b1, 10'(100 + k), 8'(8'h60 - 8'h10 * k), 3'd0);
            do_rd(2'd1, d);
        end
        run_is("R7 running at depth 4", 8'h30);
        set_cand(1'b1, 10'd104, 8'h10, 3'd0);
        chk_eq("R7 full blocks irq", {31'd0, irq}, 32'd0);
        do_rd(2'd1, d);
        chk_eq("R7 full ack spurious", d, 32'd1023);
        set_cand(1'b0, 10'd0, 8'h00, 3'd0);
        for (int k = 3; k >= 0; k--) begin
            do_wr(2'd2, 32'(100 + k));
            chk_eq("R6 drain eoi id", {22'd0, eoi_id_seen}, 32'(100 + k));
        end
        run_is("R7 drained to idle", 8'hFF);
        do_wr(2'd2, 32'd77);
        chk_eq("R6 eoi on empty ignored", {31'd0, eoi_seen}, 32'd0);
    endtask

    task automatic t_spur_eoi;
        logic [31:0] d;
        set_cand(1'b1, 10'd7, 8'h50, 3'd2);
        do_rd(2'd1, d);
        chk_eq("R3 sgi source two", d, 32'h0000_0807);
        do_wr(2'd2, 32'd1023);
        chk_eq("R6 eoi 1023 ignored", {31'd0, eoi_seen}, 32'd0);
        run_is("R6 running kept after 1023", 8'h50);
        do_wr(2'd2, 32'd7);
        run_is("R6 final pop idle", 8'hFF);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d;
        set_cand(1'b1, 10'd200, 8'h60, 3'd0);
        do_rd(2'd1, d);
        set_cand(1'b1, 10'd201, 8'h30, 3'd0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 2'd1;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd200;
        @(posedge clk); #1;
        chk_eq("R8 ack data", rd_data, 32'd201);
        chk_eq("R8 ack strobe", {31'd0, ack}, 32'd1);
        chk_eq("R8 eoi strobe", {31'd0, eoi}, 32'd1);
        chk_eq("R8 eoi id", {22'd0, eoi_id}, 32'd200);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        set_cand(1'b0, 10'd0, 8'h00, 3'd0);
        run_is("R8 top replaced", 8'h30);
        do_wr(2'd2, 32'd201);
        run_is("R8 depth unchanged", 8'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_mask();
        do_wr(2'd0, 32'hF0);
        t_nest();
        t_spurious();
        t_full();
        t_spur_eoi();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule